// File: doc/BRIEF.md
# Transmit squelch and idle generator

This block sits between the sampled transmit pair of an attachment-unit interface and the enable of an optical LED driver. Every clock it takes one sample: the polarity of the differential pair and a flag from an external comparator saying whether the swing was large enough. A sufficiently long run of large negative samples opens the squelch. From the next sample on, the pair polarity is forwarded to the LED enable with a fixed one-cycle latency. A sufficiently long run of large positive samples marks the start of idle and closes the squelch again.

Whenever packet data is not being forwarded, the LED enable carries a square wave at half the idle period per level. With a 100 MHz sample clock and the default parameters this is a 1 MHz, 50% duty wave. The wave restarts from its dark half at every start of idle. A blocking input from the jabber and link logic suppresses data forwarding but never the idle wave. A status output tells the neighbouring control blocks when a packet is being carried.

The sample input is a continuous stream with no ready signal. One sample is consumed on every clock and nothing can be held back. All other pins are plain levels.

Top module: `fl_tx_gate`

## Requirements
- R1: With `pair_pos`=0 and `pair_lvl_ok`=1 counting as a qualified negative sample, `xmit_active` rises at the clock edge that samples the NEG_MIN-th consecutive qualified negative sample. A shorter run, or a run interrupted by a sample with `pair_lvl_ok`=0, leaves it low.
- R2: The samples forming the opening run are not forwarded. The first sample after them reaches `led_drive` one cycle later, whatever the idle phase or the length of the preceding gap, so the start-up delay is always NEG_MIN+1 cycles.
- R3: While `xmit_active`=1 and `xmit_block`=0, `led_drive` in the next cycle is the inverse of `pair_pos`. Here 1 means the LED is lit, so a positive pair gives a dark LED.
- R4: With `pair_pos`=1 and `pair_lvl_ok`=1 counting as a qualified positive sample, `xmit_active` falls at the edge that samples the IDLE_RUN-th consecutive qualified positive sample. A shorter run, or a run broken by a negative sample or by a sample with `pair_lvl_ok`=0, leaves it high.
- R5: Whenever no data is forwarded, `led_drive` is a square wave with IDLE_HALF lit cycles and IDLE_HALF dark cycles, giving a period of 2×IDLE_HALF cycles.
- R6: After the edge that detects start of idle, `led_drive` stays dark for IDLE_HALF+1 cycles and is then lit for IDLE_HALF cycles.
- R7: While `xmit_block`=1, `led_drive` shows only the idle wave, even during a negative packet. Squelch tracking and `xmit_active` behave as if the block were not set.
- R8: During reset both outputs are 0. After release, the first lit `led_drive` value follows the (IDLE_HALF+1)-th clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_pos | input | 1 | Sampled transmit pair polarity, 1 = positive |
| pair_lvl_ok | input | 1 | Comparator flag: sample swing exceeds the squelch level |
| xmit_block | input | 1 | Suppress data forwarding (jabber or low light) |
| led_drive | output | 1 | Optical LED enable, 1 = lit |
| xmit_active | output | 1 | Packet being carried, from unsquelch to start of idle |

## Verification
The assertions assume one sample per clock with `pair_pos` and `pair_lvl_ok` held steady across each edge. They assume that `xmit_block` changes only between samples, never relative to a packet boundary inside a cycle. The stimulus changes every input at the falling clock edge and reads the outputs one falling edge later, so each input value is seen by exactly one rising edge. The sweeps step run lengths across the opening and closing thresholds, vary the gap before a packet across the idle period, and interrupt runs both with low-level samples and with samples of the opposite sign.

// File: rtl/fl_tx_pkg.sv
package fl_tx_pkg;
  typedef enum logic {
    SQ_QUIET = 1'b0,
    SQ_OPEN  = 1'b1
  } sq_state_e;

  // Defaults for a 100 MHz sample clock
  localparam int unsigned DEF_NEG_MIN   = 2;   // about 20 ns of negative swing
  localparam int unsigned DEF_IDLE_RUN  = 18;  // about 180 ns of positive swing
  localparam int unsigned DEF_IDLE_HALF = 50;  // half of a 1 us idle period
endpackage

// File: rtl/fl_run_detect.sv
module fl_run_detect #(
  parameter int unsigned RUN_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  output logic reached
);
  generate
    if (RUN_LEN <= 1) begin : g_single
      assign reached = hit;
    end else begin : g_count
      localparam int unsigned CNT_W = $clog2(RUN_LEN);
      localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
      logic [CNT_W-1:0] cnt_q;

      // consecutive hits seen before the current sample, saturating
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!hit)         cnt_q <= '0;
        else if (cnt_q != LAST) cnt_q <= cnt_q + CNT_W'(1);
      end

      assign reached = hit && (cnt_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/fl_idle_gen.sv
module fl_idle_gen #(
  parameter int unsigned HALF = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic phase
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (restart) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (cnt_q == TOP) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/fl_sq_fsm.sv
module fl_sq_fsm
  import fl_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_hit,
  input  logic idle_hit,
  output logic active,
  output logic soi
);
  sq_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    soi  = 1'b0;
    case (st_q)
      SQ_QUIET: if (start_hit) st_d = SQ_OPEN;
      SQ_OPEN: begin
        if (idle_hit) begin
          st_d = SQ_QUIET;
          soi  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SQ_QUIET;
    else        st_q <= st_d;
  end

  assign active = (st_q == SQ_OPEN);
endmodule

// File: rtl/fl_tx_gate.sv
module fl_tx_gate
  import fl_tx_pkg::*;
#(
  parameter int unsigned NEG_MIN   = DEF_NEG_MIN,
  parameter int unsigned IDLE_RUN  = DEF_IDLE_RUN,
  parameter int unsigned IDLE_HALF = DEF_IDLE_HALF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pair_pos,
  input  logic pair_lvl_ok,
  input  logic xmit_block,
  output logic led_drive,
  output logic xmit_active
);
  logic neg_hit, pos_hit;
  logic neg_reached, pos_reached;
  logic act, soi, idle_ph;
  logic forward, led_d, led_q;

  assign neg_hit = !pair_pos && pair_lvl_ok;
  assign pos_hit = pair_pos && pair_lvl_ok;

  fl_run_detect #(.RUN_LEN(NEG_MIN)) u_neg_run (
    .clk(clk), .rst_n(rst_n), .hit(neg_hit), .reached(neg_reached)
  );

  fl_run_detect #(.RUN_LEN(IDLE_RUN)) u_pos_run (
    .clk(clk), .rst_n(rst_n), .hit(pos_hit), .reached(pos_reached)
  );

  fl_sq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n),
    .start_hit(neg_reached), .idle_hit(pos_reached),
    .active(act), .soi(soi)
  );

  fl_idle_gen #(.HALF(IDLE_HALF)) u_idle (
    .clk(clk), .rst_n(rst_n), .restart(soi), .phase(idle_ph)
  );

  // negative pair lights the LED; idle wave whenever data is not carried
  assign forward = act && !xmit_block;
  assign led_d   = forward ? !pair_pos : idle_ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= led_d;
  end

  assign led_drive   = led_q;
  assign xmit_active = act;
endmodule

// File: rtl/fl_tx_gate_chk.sv
module fl_tx_gate_chk #(
  parameter int unsigned NEG_MIN  = 2,
  parameter int unsigned IDLE_RUN = 18
) (
  input logic clk,
  input logic rst_n,
  input logic pair_pos,
  input logic pair_lvl_ok,
  input logic xmit_block,
  input logic led_drive,
  input logic xmit_active
);
  localparam int unsigned SW = $clog2(NEG_MIN + IDLE_RUN + 2) + 1;
  localparam logic [SW-1:0] SAT = '1;

  logic [SW-1:0] neg_seen, pos_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      neg_seen <= '0;
      pos_seen <= '0;
    end else begin
      if (!pair_pos && pair_lvl_ok) neg_seen <= (neg_seen == SAT) ? SAT : neg_seen + SW'(1);
      else                          neg_seen <= '0;
      if (pair_pos && pair_lvl_ok)  pos_seen <= (pos_seen == SAT) ? SAT : pos_seen + SW'(1);
      else                          pos_seen <= '0;
    end
  end

  AST_OPEN_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xmit_active) |-> neg_seen >= SW'(NEG_MIN)); // R1

  AST_CLOSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xmit_active) |-> pos_seen >= SW'(IDLE_RUN)); // R4

  AST_FWD_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_active && !xmit_block) |=> (led_drive == !$past(pair_pos))); // R3

  AST_IDLE_RESTART_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xmit_active) |=> !led_drive); // R6
endmodule

bind fl_tx_gate fl_tx_gate_chk #(.NEG_MIN(NEG_MIN), .IDLE_RUN(IDLE_RUN)) i_fl_tx_gate_chk (
  .clk(clk), .rst_n(rst_n), .pair_pos(pair_pos), .pair_lvl_ok(pair_lvl_ok),
  .xmit_block(xmit_block), .led_drive(led_drive), .xmit_active(xmit_active)
);

// File: tb/test_fl_tx_gate.sv
module test_fl_tx_gate;
  localparam int NEG_MIN   = 2;
  localparam int IDLE_RUN  = 18;
  localparam int IDLE_HALF = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pair_pos = 1'b1;
  logic pair_lvl_ok = 1'b1;
  logic xmit_block = 1'b0;
  logic led_drive, xmit_active;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  fl_tx_gate #(.NEG_MIN(NEG_MIN), .IDLE_RUN(IDLE_RUN), .IDLE_HALF(IDLE_HALF)) i_fl_tx_gate (
    .clk(clk), .rst_n(rst_n), .pair_pos(pair_pos), .pair_lvl_ok(pair_lvl_ok),
    .xmit_block(xmit_block), .led_drive(led_drive), .xmit_active(xmit_active)
  );

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=completion", cycles);
      finish_run();
    end
  end

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic put(logic p, logic l);
    pair_pos = p;
    pair_lvl_ok = l;
  endtask

  // after tick, outputs reflect every sample put before it
  task automatic tick();
    @(negedge clk);
  endtask

  task automatic open_pkt();
    for (int i = 0; i < NEG_MIN; i++) begin put(1'b0, 1'b1); tick(); end
    check("R1 open", int'(xmit_active), 1);
  endtask

  task automatic close_run();
    for (int i = 0; i < IDLE_RUN; i++) begin put(1'b1, 1'b1); tick(); end
    check("R4 close", int'(xmit_active), 0);
  endtask

  initial begin
    int highs;
    int exp_led;
    logic d;

    // R8 reset state
    tick(); tick();
    check("R8 led in reset", int'(led_drive), 0);
    check("R8 active in reset", int'(xmit_active), 0);
    rst_n = 1'b1;
    for (int k = 1; k <= 2 * IDLE_HALF + 5; k++) begin
      tick();
      check("R8 idle phase after reset", int'(led_drive), ((k - 1) / IDLE_HALF) % 2);
    end

    // R1 opening run length sweep
    for (int len = 1; len <= NEG_MIN + 3; len++) begin
      for (int i = 1; i <= len; i++) begin
        put(1'b0, 1'b1); tick();
        check("R1 run sweep", int'(xmit_active), (i >= NEG_MIN) ? 1 : 0);
      end
      put(1'b1, 1'b1); tick();
      close_run();
    end

    // R1 negative samples below level never open
    for (int i = 0; i < 3 * NEG_MIN + 4; i++) begin
      put(1'b0, 1'b0); tick();
      check("R1 low level", int'(xmit_active), 0);
    end
    // R1 level drop inside a run
    for (int i = 0; i < NEG_MIN - 1; i++) begin put(1'b0, 1'b1); tick(); end
    put(1'b0, 1'b0); tick();
    for (int i = 0; i < NEG_MIN - 1; i++) begin put(1'b0, 1'b1); tick(); end
    check("R1 broken run", int'(xmit_active), 0);
    close_run();

    // R4 closing run length sweep
    for (int len = 1; len <= IDLE_RUN + 2; len++) begin
      open_pkt();
      for (int j = 1; j <= len; j++) begin
        put(1'b1, 1'b1); tick();
        check("R4 run sweep", int'(xmit_active), (j < IDLE_RUN) ? 1 : 0);
      end
      put(1'b0, 1'b1); tick();
      check("R4 after run", int'(xmit_active), (len < IDLE_RUN) ? 1 : 0);
      close_run();
    end

    // R4 positive run broken by low level
    open_pkt();
    for (int i = 0; i < IDLE_RUN - 1; i++) begin put(1'b1, 1'b1); tick(); end
    put(1'b1, 1'b0); tick();
    for (int i = 0; i < IDLE_RUN - 1; i++) begin put(1'b1, 1'b1); tick(); end
    check("R4 level break", int'(xmit_active), 1);
    close_run();

    // R2 and R3 forwarding after gaps covering the idle period
    for (int s = 0; s < 7; s++) begin
      for (int g = 0; g < 13 * s; g++) begin put(1'b1, 1'b1); tick(); end
      open_pkt();
      for (int i = 0; i < 24; i++) begin
        d = (i == 0) ? 1'b1 : 1'(((i * 3 + s) / 4) % 2);
        put(d, 1'b1); tick();
        if (i < 2) check("R2 first forwarded sample", int'(led_drive), d ? 0 : 1);
        else       check("R3 polarity", int'(led_drive), d ? 0 : 1);
      end
      close_run();
    end

    // R6 and R5 idle restart and waveform after start of idle
    open_pkt();
    put(1'b0, 1'b1); tick();
    for (int i = 0; i < IDLE_RUN; i++) begin put(1'b1, 1'b1); tick(); end
    check("R6 dark at detection", int'(led_drive), 0);
    check("R4 closed", int'(xmit_active), 0);
    for (int k = 1; k <= 3 * IDLE_HALF + 2; k++) begin
      tick();
      exp_led = ((k - 1) / IDLE_HALF) % 2;
      if (k <= 2 * IDLE_HALF + 1) check("R6 restart phase", int'(led_drive), exp_led);
      else                        check("R5 idle period", int'(led_drive), exp_led);
    end

    // R7 block during a packet
    open_pkt();
    xmit_block = 1'b1;
    highs = 0;
    for (int i = 0; i < 4 * IDLE_HALF; i++) begin
      put(1'b0, 1'b1); tick();
      highs += int'(led_drive);
    end
    check("R7 idle only while blocked", highs, 2 * IDLE_HALF);
    check("R7 active while blocked", int'(xmit_active), 1);
    close_run();
    highs = 0;
    for (int i = 0; i < 4 * IDLE_HALF; i++) begin
      put(1'b1, 1'b1); tick();
      highs += int'(led_drive);
    end
    check("R5 duty while quiet", highs, 2 * IDLE_HALF);
    xmit_block = 1'b0;
    open_pkt();
    put(1'b0, 1'b1); tick();
    check("R7 forwarding resumes", int'(led_drive), 1);
    close_run();

    finish_run();
  end
endmodule